// File: doc/BRIEF.md
# Card Register Programming Frame Checker

This block sits on the card side of a memory-card data path. It receives the serial data frame that rewrites the card's fixed-format configuration register. The frame is taken only once the programming command has been answered. The command decoder signals that moment with a one-cycle arm pulse. The block then waits on the data line for a low start bit. It shifts in the register image and its 16-bit checksum, most significant bit first, and samples a closing high bit. The frame length is always the register width. No block-length setting plays any part in it.

When the closing bit is sampled, the block decides the outcome. If the checksum is wrong or the closing bit is missing, the write is refused as a transmission error. If any bit outside the writable mask differs from the stored register, the write is refused as a content error. Only a clean frame is committed, and it changes only the writable bits. A refused frame leaves the register untouched. After every commit the block recomputes the 7-bit check over the upper part of the register and compares it with the field the register holds for it. A flag shows whether they disagree.

Top module: `cardreg_prog_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `reg_q` equals `INIT_IMAGE`, `done` is 0, `res_code` is 0 and `crc7_bad` is 0.
- R2: Bits presented on the data line while the block is not armed change nothing: no `done` pulse appears and `reg_q` keeps its value.
- R3: After an arm pulse, sampled high bits are ignored until a sampled low start bit. The frame then runs REG_W image bits and 16 checksum bits, both MSB first, then one closing bit. `done` is high for exactly one cycle, in the cycle after the closing bit is sampled.
- R4: A frame with a good checksum, a high closing bit and matching protected bits gives `res_code` = 0. Bits set in `WR_MASK` take the received values. All other bits keep their stored values.
- R5: A frame whose checksum is good but whose image differs from `reg_q` in any bit outside `WR_MASK` gives `res_code` = 2. `reg_q` is left unchanged.
- R6: The checksum is the CRC16 with polynomial 0x1021 and zero start value, taken over the REG_W image bits. A received checksum that differs gives `res_code` = 1 and leaves `reg_q` unchanged.
- R7: A closing bit sampled as 0 gives `res_code` = 1 and leaves `reg_q` unchanged.
- R8: When the checksum fails and the protected bits also differ, `res_code` is 1.
- R9: After a commit, `crc7_bad` is 1 exactly when the CRC7 (polynomial 0x09, zero start value, MSB first) over `reg_q[REG_W-1:8]` differs from `reg_q[7:1]`. A refused frame leaves `crc7_bad` as it was.
- R10: Cycles with `dat_vld` low consume no bit at any point in the frame.
- R11: An arm pulse during a frame drops the partial frame and restarts the hunt for a start bit. A bit presented in the same cycle as an arm pulse is discarded.
- R12: After `done`, the block is unarmed again, and a new frame needs a new arm pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_arm | input | 1 | One-cycle pulse after the programming command's response has been sent |
| dat_vld | input | 1 | Marks a cycle in which `dat_in` holds a sampled line bit |
| dat_in | input | 1 | Serial data line bit |
| reg_q | output | REG_W | Stored register contents |
| done | output | 1 | One-cycle pulse when a frame has been judged |
| res_code | output | 2 | Last outcome: 0 committed, 1 checksum or closing-bit error, 2 protected-bit mismatch |
| crc7_bad | output | 1 | Stored 7-bit check field disagrees with the recomputed CRC7 |

## Verification
The bench builds the block with REG_W = 32, a writable mask of the low 16 bits and a nonzero initial image. This keeps each frame short enough to sweep every single protected bit flip and every single checksum bit flip. It also allows dozens of committed writes with varied idle prefixes and stall gaps. Because the writable field covers bits [7:1], the bench can write both correct and wrong 7-bit check values. This exercises both outcomes of the recomputed check. The bench also drives start-less and unarmed frames, re-arms in the middle of a frame, and sends frames that break both the checksum and the protected bits.

// File: rtl/rp_pkg.sv
package rp_pkg;

    localparam logic [15:0]  CRC16_POLY = 16'h1021;
    localparam logic [6:0]   CRC7_POLY  = 7'h09;
    localparam int unsigned  CRC16_W    = 16;
    localparam int unsigned  MAX_IMG_W  = 256;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_HUNT,
        SEQ_DATA,
        SEQ_CRC,
        SEQ_END
    } seq_e;

    typedef enum logic [1:0] {
        RES_OK  = 2'd0,
        RES_CRC = 2'd1,
        RES_CMP = 2'd2
    } res_e;

    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
        return {c[14:0], 1'b0} ^ (((b ^ c[15]) == 1'b1) ? CRC16_POLY : 16'h0000);
    endfunction

    function automatic logic [6:0] crc7_step(input logic [6:0] c, input logic b);
        return {c[5:0], 1'b0} ^ (((b ^ c[6]) == 1'b1) ? CRC7_POLY : 7'h00);
    endfunction

    // CRC7 over v[n-1:0], most significant bit first
    function automatic logic [6:0] crc7_span(input logic [MAX_IMG_W-1:0] v, input int unsigned n);
        logic [6:0] c;
        c = '0;
        for (int i = int'(MAX_IMG_W) - 1; i >= 0; i--) begin
            if (i < int'(n)) c = crc7_step(c, v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/rp_frame_seq.sv
module rp_frame_seq
    import rp_pkg::*;
#(
    parameter int unsigned REG_W = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic prog_arm,
    input  logic dat_vld,
    input  logic dat_in,
    output logic stb_start,
    output logic stb_data,
    output logic stb_crc,
    output logic stb_fin
);
    localparam int unsigned CNT_W = $clog2(REG_W);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(REG_W - 1);
    localparam logic [CNT_W-1:0] LAST_CRC  = CNT_W'(CRC16_W - 1);

    seq_e             st;
    logic [CNT_W-1:0] cnt;
    logic             take;

    assign take = dat_vld && !prog_arm;

    always_comb begin
        stb_start = 1'b0;
        stb_data  = 1'b0;
        stb_crc   = 1'b0;
        stb_fin   = 1'b0;
        if (take) begin
            case (st)
                SEQ_HUNT: stb_start = !dat_in;
                SEQ_DATA: stb_data  = 1'b1;
                SEQ_CRC:  stb_crc   = 1'b1;
                SEQ_END:  stb_fin   = 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SEQ_IDLE;
            cnt <= '0;
        end else if (prog_arm) begin
            st  <= SEQ_HUNT;
            cnt <= '0;
        end else if (take) begin
            case (st)
                SEQ_HUNT: if (!dat_in) begin
                    st  <= SEQ_DATA;
                    cnt <= '0;
                end
                SEQ_DATA: if (cnt == LAST_DATA) begin
                    st  <= SEQ_CRC;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SEQ_CRC: if (cnt == LAST_CRC) begin
                    st  <= SEQ_END;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SEQ_END: st <= SEQ_IDLE;
                default: st <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rp_crc16_rx.sv
module rp_crc16_rx
    import rp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stb_start,
    input  logic stb_data,
    input  logic stb_crc,
    input  logic dat_in,
    output logic crc_ok
);
    logic [15:0] calc_q;
    logic [15:0] recv_q;

    always_ff @(posedge clk) begin
        if (rst || stb_start) begin
            calc_q <= '0;
            recv_q <= '0;
        end else begin
            if (stb_data) calc_q <= crc16_step(calc_q, dat_in);
            if (stb_crc)  recv_q <= {recv_q[14:0], dat_in};
        end
    end

    assign crc_ok = (calc_q == recv_q);

endmodule

// File: rtl/rp_img_store.sv
module rp_img_store
    import rp_pkg::*;
#(
    parameter int unsigned      REG_W      = 128,
    parameter logic [REG_W-1:0] WR_MASK    = {{(REG_W-16){1'b0}}, 16'hFFFF},
    parameter logic [REG_W-1:0] INIT_IMAGE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb_data,
    input  logic             stb_fin,
    input  logic             dat_in,
    input  logic             crc_ok,
    output logic [REG_W-1:0] reg_q,
    output logic             done,
    output res_e             res,
    output logic             crc7_bad
);
    localparam logic [REG_W-1:0] PROT_MASK = ~WR_MASK;
    localparam int unsigned      C7_SPAN   = REG_W - 8;

    logic [REG_W-1:0] img_sr;
    logic [REG_W-1:0] merged;
    logic             prot_diff;
    logic             frame_ok;
    logic [6:0]       c7_calc;

    assign prot_diff = |((img_sr ^ reg_q) & PROT_MASK);
    assign frame_ok  = crc_ok && dat_in;
    assign merged    = (reg_q & PROT_MASK) | (img_sr & WR_MASK);
    assign c7_calc   = crc7_span(MAX_IMG_W'(merged[REG_W-1:8]), C7_SPAN);

    always_ff @(posedge clk) begin
        if (rst) begin
            img_sr   <= '0;
            reg_q    <= INIT_IMAGE;
            done     <= 1'b0;
            res      <= RES_OK;
            crc7_bad <= 1'b0;
        end else begin
            done <= stb_fin;
            if (stb_data) img_sr <= {img_sr[REG_W-2:0], dat_in};
            if (stb_fin) begin
                if (!frame_ok) begin
                    res <= RES_CRC;
                end else if (prot_diff) begin
                    res <= RES_CMP;
                end else begin
                    res      <= RES_OK;
                    reg_q    <= merged;
                    crc7_bad <= (c7_calc != merged[7:1]);
                end
            end
        end
    end

endmodule

// File: rtl/cardreg_prog_unit.sv
module cardreg_prog_unit
    import rp_pkg::*;
#(
    parameter int unsigned      REG_W      = 128,
    parameter logic [REG_W-1:0] WR_MASK    = {{(REG_W-16){1'b0}}, 16'hFFFF},
    parameter logic [REG_W-1:0] INIT_IMAGE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             prog_arm,
    input  logic             dat_vld,
    input  logic             dat_in,
    output logic [REG_W-1:0] reg_q,
    output logic             done,
    output logic [1:0]       res_code,
    output logic             crc7_bad
);
    logic stb_start, stb_data, stb_crc, stb_fin;
    logic crc_ok;
    res_e res;

    rp_frame_seq #(.REG_W(REG_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .prog_arm  (prog_arm),
        .dat_vld   (dat_vld),
        .dat_in    (dat_in),
        .stb_start (stb_start),
        .stb_data  (stb_data),
        .stb_crc   (stb_crc),
        .stb_fin   (stb_fin)
    );

    rp_crc16_rx u_crc (
        .clk       (clk),
        .rst       (rst),
        .stb_start (stb_start),
        .stb_data  (stb_data),
        .stb_crc   (stb_crc),
        .dat_in    (dat_in),
        .crc_ok    (crc_ok)
    );

    rp_img_store #(
        .REG_W      (REG_W),
        .WR_MASK    (WR_MASK),
        .INIT_IMAGE (INIT_IMAGE)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .stb_data (stb_data),
        .stb_fin  (stb_fin),
        .dat_in   (dat_in),
        .crc_ok   (crc_ok),
        .reg_q    (reg_q),
        .done     (done),
        .res      (res),
        .crc7_bad (crc7_bad)
    );

    assign res_code = res;

endmodule

// File: rtl/cardreg_prog_unit_chk.sv
module cardreg_prog_unit_chk #(
    parameter int unsigned      REG_W      = 128,
    parameter logic [REG_W-1:0] WR_MASK    = {{(REG_W-16){1'b0}}, 16'hFFFF},
    parameter logic [REG_W-1:0] INIT_IMAGE = '0
) (
    input logic             clk,
    input logic             rst,
    input logic [REG_W-1:0] reg_q,
    input logic             done,
    input logic [1:0]       res_code,
    input logic             crc7_bad
);
    localparam logic [REG_W-1:0] PROT_MASK = ~WR_MASK;

    logic seen_clk = 1'b0;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    // R1: state right after reset
    assert_reset_state_R1: assert property (@(posedge clk)
        (seen_clk && $past(rst)) |-> (reg_q == INIT_IMAGE && !done && res_code == 2'd0 && !crc7_bad));

    // R3: done lasts a single cycle
    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2 / R12: the register moves only in the cycle a verdict is shown
    assert_quiet_reg_R2: assert property (@(posedge clk) disable iff (rst)
        !done |-> (reg_q == $past(reg_q)));

    // R4: a commit never alters protected bits
    assert_commit_mask_R4: assert property (@(posedge clk) disable iff (rst)
        (done && res_code == 2'd0) |-> (((reg_q ^ $past(reg_q)) & PROT_MASK) == '0));

    // R5 (also R6, R7): a refused frame leaves register and flag alone
    assert_reject_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (done && res_code != 2'd0) |-> (reg_q == $past(reg_q) && crc7_bad == $past(crc7_bad)));

    // R8: only defined result codes appear
    assert_code_legal_R8: assert property (@(posedge clk) disable iff (rst)
        res_code != 2'd3);

endmodule

bind cardreg_prog_unit cardreg_prog_unit_chk #(
    .REG_W      (REG_W),
    .WR_MASK    (WR_MASK),
    .INIT_IMAGE (INIT_IMAGE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_q    (reg_q),
    .done     (done),
    .res_code (res_code),
    .crc7_bad (crc7_bad)
);

// File: tb/cardreg_prog_unit_bench.sv
module cardreg_prog_unit_bench;

    localparam int unsigned W    = 32;
    localparam logic [W-1:0] MASK = 32'h0000_FFFF;
    localparam logic [W-1:0] PROT = ~MASK;
    localparam logic [W-1:0] INIT = 32'h5AC3_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         prog_arm = 1'b0;
    logic         dat_vld = 1'b0;
    logic         dat_in = 1'b0;
    logic [W-1:0] reg_q;
    logic         done;
    logic [1:0]   res_code;
    logic         crc7_bad;

    int vectors = 0;
    int fails = 0;
    int done_cnt = 0;
    bit finished = 0;

    logic [W-1:0] exp_reg = INIT;
    logic         exp_c7 = 1'b0;

    always #2 clk = ~clk;

    cardreg_prog_unit #(.REG_W(W), .WR_MASK(MASK), .INIT_IMAGE(INIT)) u_cardreg_prog_unit (
        .clk(clk), .rst(rst), .prog_arm(prog_arm), .dat_vld(dat_vld), .dat_in(dat_in),
        .reg_q(reg_q), .done(done), .res_code(res_code), .crc7_bad(crc7_bad)
    );

    always @(negedge clk) if (done) done_cnt++;

    // remainder of data * x^16 divided by the generator, long division
    function automatic logic [15:0] ref_crc16(input logic [W-1:0] d);
        logic [16:0] r = '0;
        for (int i = W + 15; i >= 0; i--) begin
            r = {r[15:0], (i >= 16) ? d[i-16] : 1'b0};
            if (r[16]) r = r ^ 17'h11021;
        end
        return r[15:0];
    endfunction

    function automatic logic [6:0] ref_crc7(input logic [W-9:0] d);
        logic [7:0] r = '0;
        for (int i = W - 8 + 6; i >= 0; i--) begin
            r = {r[6:0], (i >= 7) ? d[i-7] : 1'b0};
            if (r[7]) r = r ^ 8'h89;
        end
        return r[6:0];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        @(negedge clk);
        dat_vld = 1'b1;
        dat_in  = b;
    endtask

    task automatic stall();
        @(negedge clk);
        dat_vld = 1'b0;
        dat_in  = 1'b0;
    endtask

    task automatic arm();
        @(negedge clk);
        dat_vld  = 1'b0;
        prog_arm = 1'b1;
        @(negedge clk);
        prog_arm = 1'b0;
    endtask

    task automatic send_raw(input logic [W-1:0] img, input logic [15:0] crc,
                            input logic endb, input int pre, input int gap);
        for (int i = 0; i < pre; i++) drive_bit(1'b1);
        if (gap != 0) stall();
        drive_bit(1'b0);
        for (int i = W - 1; i >= 0; i--) begin
            drive_bit(img[i]);
            if (gap != 0 && (i % gap) == 0) stall();
        end
        for (int i = 15; i >= 0; i--) drive_bit(crc[i]);
        drive_bit(endb);
        stall();
    endtask

    task automatic frame(input string tag, input logic [W-1:0] img, input logic [15:0] crc_flip,
                         input logic endb, input int pre, input int gap);
        logic       bad_crc;
        logic       bad_cmp;
        logic [1:0] exp_code;
        int         d0;
        bad_crc = (crc_flip != 16'h0) || !endb;
        bad_cmp = ((img ^ exp_reg) & PROT) != '0;
        exp_code = bad_crc ? 2'd1 : (bad_cmp ? 2'd2 : 2'd0);
        if (exp_code == 2'd0) begin
            exp_reg = (exp_reg & PROT) | (img & MASK);
            exp_c7  = ref_crc7(exp_reg[W-1:8]) != exp_reg[7:1];
        end
        arm();
        d0 = done_cnt;
        send_raw(img, ref_crc16(img) ^ crc_flip, endb, pre, gap);
        chk({tag, " R3 done high"}, 64'(done), 64'd1);
        chk({tag, " result code"}, 64'(res_code), 64'(exp_code));
        chk({tag, " register"}, 64'(reg_q), 64'(exp_reg));
        chk({tag, " R9 crc7 flag"}, 64'(crc7_bad), 64'(exp_c7));
        @(negedge clk);
        chk({tag, " R3 done single"}, 64'(done), 64'd0);
        chk({tag, " R3 one pulse"}, 64'(done_cnt - d0), 64'd1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] img;
        int d0;
        repeat (4) @(negedge clk);
        chk("R1 reg after reset", 64'(reg_q), 64'(INIT));
        chk("R1 done after reset", 64'(done), 64'd0);
        chk("R1 code after reset", 64'(res_code), 64'd0);
        chk("R1 crc7 flag after reset", 64'(crc7_bad), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reg first cycle", 64'(reg_q), 64'(INIT));
        chk("R1 done first cycle", 64'(done), 64'd0);

        // R2: a well-formed frame without an arm pulse
        d0 = done_cnt;
        img = (INIT & PROT) | 32'h0000_1234;
        send_raw(img, ref_crc16(img), 1'b1, 2, 0);
        repeat (3) stall();
        chk("R2 no done unarmed", 64'(done_cnt - d0), 64'd0);
        chk("R2 reg unarmed", 64'(reg_q), 64'(INIT));

        // R4 R9 R10 R3: committed writes, varied prefix and stalls
        for (int k = 0; k < 48; k++) begin
            logic [15:0] low;
            low = 16'(k * 16'h0409) ^ 16'hA55A;
            img = (exp_reg & PROT) | {16'h0, low};
            if (k % 2 == 0) img[7:1] = ref_crc7(img[W-1:8]);
            if (k % 5 == 4) img[W-1:16] = ~exp_reg[W-1:16];
            frame($sformatf("R4 write %0d", k), img, 16'h0, 1'b1, k % 4, k % 3 == 0 ? 0 : (k % 3) + 2);
        end

        // R5: each single protected bit flipped
        for (int b = 16; b < W; b++) begin
            img = exp_reg ^ (32'h1 << b);
            frame($sformatf("R5 prot bit %0d", b), img, 16'h0, 1'b1, 1, 0);
        end

        // R6: each single checksum bit flipped
        for (int b = 0; b < 16; b++) begin
            img = (exp_reg & PROT) | 32'h0000_0F0F;
            frame($sformatf("R6 crc bit %0d", b), img, 16'(16'h1 << b), 1'b1, 0, 0);
        end

        // R7: closing bit low
        img = (exp_reg & PROT) | 32'h0000_BEEF;
        frame("R7 end bit low", img, 16'h0, 1'b0, 0, 5);

        // R8: checksum and protected bits both wrong
        img = exp_reg ^ 32'h0100_0077;
        frame("R8 both errors", img, 16'h8001, 1'b1, 1, 0);

        // R11: re-arm in the middle of a frame
        arm();
        d0 = done_cnt;
        drive_bit(1'b0);
        for (int i = 0; i < 10; i++) drive_bit(i[0]);
        stall();
        chk("R11 no done partial", 64'(done_cnt - d0), 64'd0);
        img = (exp_reg & PROT) | 32'h0000_C3A1;
        frame("R11 after rearm", img, 16'h0, 1'b1, 2, 0);

        // R12: done returns to unarmed
        d0 = done_cnt;
        img = (exp_reg & PROT) | 32'h0000_7777;
        send_raw(img, ref_crc16(img), 1'b1, 0, 0);
        repeat (3) stall();
        chk("R12 no done after verdict", 64'(done_cnt - d0), 64'd0);
        chk("R12 reg after verdict", 64'(reg_q), 64'(exp_reg));

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule